// File: doc/BRIEF.md
# Fabric Input Staging Queue with Lane-Aligned Loads

This block sits between a processor core's load path and a shared reconfigurable fabric. Special load operations deliver 128-bit quadwords. Each load names one of four lanes inside the 512-bit entry being built. Once all four lanes hold data, or software closes the entry early with a commit strobe, the entry moves into a small FIFO. The fabric reads that FIFO at one quarter of the core rate. Loads arrive at up to four times the drain rate, so the FIFO applies back-pressure through a ready signal.

The fabric clock is modelled inside the single core clock domain as a clock enable that is high one cycle in four. Results flow the other way through a single 128-bit output staging register. The register captures one fabric result and keeps it until a special store operation takes it. While it is occupied, the register holds the fabric off with a stall signal.

Top module: `fabq_top`

## Requirements
- R1: After reset: `fab_valid` is 0, `ld_ready` is 1, `res_stall` is 0 and `st_valid` is 0.
- R2: A load accepted with lane index L (0 to 3) places `ld_data` in bits [128*L+127 : 128*L] of the entry being built.
- R3: A partly built entry is not visible to the fabric. `fab_valid` stays 0 until the entry is closed. Once `fab_valid` is 1, it and `fab_data` hold steady until that entry is popped.
- R4: An accepted `ld_commit` closes the current entry early. The entry includes any lane written in the same cycle, and its unwritten lanes read as zero. A commit when no lane is written, and no load in the same cycle, is ignored.
- R5: Closed entries are delivered in order. The FIFO holds up to 4 entries. `ld_ready` is 0 while 4 are held, and a load or commit offered while `ld_ready` is 0 has no effect.
- R6: `fab_en` is high for exactly one cycle in every four. It first goes high in the third cycle after reset is released.
- R7: The head entry is removed only at a clock edge where `fab_en`, `fab_valid` and `fab_accept` are all 1.
- R8: The output register captures `res_data` at an edge where `fab_en` and `res_valid` are 1 and the register is empty. While full it asserts `res_stall`, and further results do not change its contents.
- R9: With the register full, `st_req` gives `st_valid` = 1 in that same cycle, with the held result on `st_data`, and the register is empty after the edge. With the register empty, `st_req` gives `st_valid` = 0.
- R10: Writing a lane again before its entry closes replaces that lane's earlier data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Lane load present |
| ld_lane | input | 2 | Target lane of the load |
| ld_data | input | 128 | Load quadword |
| ld_commit | input | 1 | Close the current entry early |
| ld_ready | output | 1 | Queue can take a load or commit |
| fab_en | output | 1 | Fabric-rate clock enable (1 in 4) |
| fab_valid | output | 1 | Head entry available |
| fab_data | output | 512 | Head entry |
| fab_accept | input | 1 | Fabric takes the head on a `fab_en` cycle |
| res_valid | input | 1 | Fabric result present |
| res_data | input | 128 | Fabric result |
| res_stall | output | 1 | Output register occupied |
| st_req | input | 1 | Store operation requests the result |
| st_valid | output | 1 | Store handshake completes this cycle |
| st_data | output | 128 | Held result |

## Verification
The bench builds entries in three ways: lanes written in order, lanes written out of order with one lane written twice, and an entry closed early by a commit. A design that leaked partial entries, misplaced a lane, kept stale data or failed to zero unwritten lanes would produce an entry that does not match the scoreboard. A bare commit and a load offered to a full queue are both slipped in. A design that pushed an empty entry or accepted the blocked load would show an extra entry, or a stray lane in the next committed entry. The output register is driven with a second result while it is full, and with a store while it is empty. Such a design would overwrite the held result or report a false store.

// File: rtl/fabq_pkg.sv
package fabq_pkg;
  localparam int unsigned QUAD_W    = 128;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned Q_DEPTH   = 4;
  localparam int unsigned RATE_DIV  = 4;
endpackage

// File: rtl/fabq_clkdiv.sv
module fabq_clkdiv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic en
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign en = (cnt_q == LAST);
endmodule

// File: rtl/fabq_assemble.sv
module fabq_assemble #(
  parameter int unsigned LANE_W = 128,
  parameter int unsigned LANES  = 4,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned ENT_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_lane,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              commit_en,
  output logic              push,
  output logic [ENT_W-1:0]  push_data
);
  logic [LANE_W-1:0] lane_q  [LANES];
  logic [LANE_W-1:0] lane_nx [LANES];
  logic [LANE_W-1:0] lane_d  [LANES];
  logic [LANES-1:0]  mask_q, mask_nx, mask_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit;
    assign hit        = wr_en && (wr_lane == IDX_W'(i));
    assign lane_nx[i] = hit ? wr_data : lane_q[i];
    assign mask_nx[i] = mask_q[i] | hit;
    assign push_data[i*LANE_W +: LANE_W] = lane_nx[i];
    assign lane_d[i]  = push ? '0 : lane_nx[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[i] <= '0;
      else        lane_q[i] <= lane_d[i];
    end
  end

  always_comb begin
    push   = (&mask_nx) || (commit_en && (|mask_nx));
    mask_d = push ? '0 : mask_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/fabq_fifo.sv
module fabq_fifo #(
  parameter int unsigned W     = 512,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_d    = do_push ? ((wr_q == LAST) ? '0 : wr_q + 1'b1) : wr_q;
    rd_d    = do_pop  ? ((rd_q == LAST) ? '0 : rd_q + 1'b1) : rd_q;
    cnt_d   = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == PW'(i))) mem_q[i] <= push_data;
    end
  end

  assign head  = mem_q[rd_q];
  assign full  = (cnt_q == FULLC);
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/fabq_outreg.sv
module fabq_outreg #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fab_en,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  input  logic         st_req,
  output logic         stall,
  output logic         st_valid,
  output logic [W-1:0] st_data
);
  logic         full_q, full_d, cap, drain;
  logic [W-1:0] data_q, data_d;

  always_comb begin
    cap    = fab_en && res_valid && !full_q;
    drain  = st_req && full_q;
    full_d = cap ? 1'b1 : (drain ? 1'b0 : full_q);
    data_d = cap ? res_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign stall    = full_q;
  assign st_valid = drain;
  assign st_data  = data_q;
endmodule

// File: rtl/fabq_top.sv
module fabq_top
  import fabq_pkg::*;
#(
  parameter int unsigned LANE_W = QUAD_W,
  parameter int unsigned LANES  = NUM_LANES,
  parameter int unsigned DEPTH  = Q_DEPTH,
  parameter int unsigned DIV    = RATE_DIV,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned ENT_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_lane,
  input  logic [LANE_W-1:0] ld_data,
  input  logic              ld_commit,
  output logic              ld_ready,
  output logic              fab_en,
  output logic              fab_valid,
  output logic [ENT_W-1:0]  fab_data,
  input  logic              fab_accept,
  input  logic              res_valid,
  input  logic [LANE_W-1:0] res_data,
  output logic              res_stall,
  input  logic              st_req,
  output logic              st_valid,
  output logic [LANE_W-1:0] st_data
);
  logic             q_full, q_empty, a_push;
  logic [ENT_W-1:0] a_data;

  fabq_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(fab_en)
  );

  fabq_assemble #(.LANE_W(LANE_W), .LANES(LANES)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_valid && ld_ready), .wr_lane(ld_lane), .wr_data(ld_data),
    .commit_en(ld_commit && ld_ready),
    .push(a_push), .push_data(a_data)
  );

  fabq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(a_push), .push_data(a_data),
    .pop(fab_en && fab_accept),
    .head(fab_data), .full(q_full), .empty(q_empty)
  );

  fabq_outreg #(.W(LANE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fab_en(fab_en),
    .res_valid(res_valid), .res_data(res_data), .st_req(st_req),
    .stall(res_stall), .st_valid(st_valid), .st_data(st_data)
  );

  assign ld_ready  = !q_full;
  assign fab_valid = !q_empty;
endmodule

// File: rtl/fabq_chk.sv
module fabq_chk #(
  parameter int unsigned ENT_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_ready,
  input logic             fab_en,
  input logic             fab_valid,
  input logic [ENT_W-1:0] fab_data,
  input logic             fab_accept,
  input logic             res_stall,
  input logic             st_req,
  input logic             st_valid
);
  assert_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fab_valid && !(fab_en && fab_accept) |=> fab_valid && $stable(fab_data));

  assert_full_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |-> fab_valid);

  assert_en_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fab_en |=> !fab_en);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_stall && !st_req |=> res_stall);

  assert_store_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> res_stall);

  assert_store_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !res_stall);
endmodule

bind fabq_top fabq_chk #(.ENT_W(ENT_W)) u_chk (.*);

// File: tb/sim_fabq_top.sv
module sim_fabq_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ld_valid, ld_commit, ld_ready;
  logic [1:0]   ld_lane;
  logic [127:0] ld_data;
  logic         fab_en, fab_valid, fab_accept;
  logic [511:0] fab_data;
  logic         res_valid, res_stall, st_req, st_valid;
  logic [127:0] res_data, st_data;

  always #2.5 clk = ~clk;

  fabq_top u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [511:0] exp_q[$];
  logic [511:0] m_asm;
  logic [3:0]   m_mask;
  int cyc = 0, last_en = -1, en_seen = 0;

  task automatic check(input bit ok, input string req,
                       input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  // monitor: fabric rate spacing and scoreboard pops
  always @(negedge clk) if (rst_n) begin
    if (fab_en) begin
      if (last_en < 0) check(cyc == 3, "R6 first", 512'(cyc), 512'd3);
      else             check(cyc - last_en == 4, "R6 spacing", 512'(cyc - last_en), 512'd4);
      last_en = cyc;
      en_seen++;
    end
    if (fab_en && fab_valid && fab_accept) begin
      if (exp_q.size() == 0) check(1'b0, "R4/R5 extra entry", fab_data, 512'd0);
      else begin
        logic [511:0] e;
        e = exp_q.pop_front();
        check(fab_data === e, "R2/R5 entry", fab_data, e);
      end
    end
  end

  // driver: one load/commit, model updated from requirements
  task automatic ld(input int lane, input logic [127:0] d, input bit wr, input bit cmt);
    ld_valid = wr; ld_lane = 2'(lane); ld_data = d; ld_commit = cmt;
    if (ld_ready) begin
      if (wr) begin m_asm[lane*128 +: 128] = d; m_mask[lane] = 1'b1; end
      if (m_mask == 4'hF || (cmt && m_mask != 0)) begin
        exp_q.push_back(m_asm); m_asm = '0; m_mask = '0;
      end
    end
    @(posedge clk); #1;
    ld_valid = 0; ld_commit = 0;
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 512'd0, 512'd1);
    finish_run();
  end

  initial begin
    rst_n = 0; ld_valid = 0; ld_commit = 0; ld_lane = 0; ld_data = '0;
    fab_accept = 0; res_valid = 0; res_data = '0; st_req = 0;
    m_asm = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    check(fab_valid == 0, "R1 fab_valid", 512'(fab_valid), 512'd0);
    check(ld_ready == 1,  "R1 ld_ready", 512'(ld_ready), 512'd1);
    check(res_stall == 0, "R1 res_stall", 512'(res_stall), 512'd0);
    check(st_valid == 0,  "R1 st_valid", 512'(st_valid), 512'd0);
    rst_n = 1;
    @(posedge clk); #1;

    // in-order lanes; R3 no early visibility
    ld(0, {4{32'hA0A0_0000}}, 1, 0);
    ld(1, {4{32'hA1A1_1111}}, 1, 0);
    ld(2, {4{32'hA2A2_2222}}, 1, 0);
    @(negedge clk);
    check(fab_valid == 0, "R3 partial hidden", 512'(fab_valid), 512'd0);
    @(posedge clk); #1;
    ld(3, {4{32'hA3A3_3333}}, 1, 0);
    @(negedge clk);
    check(fab_valid == 1, "R3 complete visible", 512'(fab_valid), 512'd1);
    @(posedge clk); #1;

    // out of order with rewrite of lane 0 (R10)
    ld(2, {4{32'hB2B2_2222}}, 1, 0);
    ld(0, {4{32'hDEAD_BEEF}}, 1, 0);
    ld(0, {4{32'hB0B0_0000}}, 1, 0);
    ld(3, {4{32'hB3B3_3333}}, 1, 0);
    ld(1, {4{32'hB1B1_1111}}, 1, 0);

    // early commit with one lane (R4), then bare commit ignored (R4)
    ld(1, {4{32'hC1C1_1111}}, 1, 1);
    ld(0, '0, 0, 1);

    // fill to depth (R5)
    ld(0, {4{32'hD0D0_0000}}, 1, 0);
    ld(1, {4{32'hD1D1_1111}}, 1, 0);
    ld(2, {4{32'hD2D2_2222}}, 1, 0);
    ld(3, {4{32'hD3D3_3333}}, 1, 0);
    @(negedge clk);
    check(ld_ready == 0, "R5 full not ready", 512'(ld_ready), 512'd0);
    check(exp_q.size() == 4, "R5 depth", 512'(exp_q.size()), 512'd4);
    @(posedge clk); #1;
    ld(0, {4{32'h5757_5757}}, 1, 0);   // blocked load, must vanish

    // no pop without accept (R7)
    begin
      int seen;
      seen = 0;
      while (seen < 3) begin
        @(negedge clk);
        if (fab_en) begin
          seen++;
          check(fab_valid && fab_data === exp_q[0], "R7 held without accept", fab_data, exp_q[0]);
        end
      end
    end
    @(posedge clk); #1;
    fab_accept = 1;
    while (exp_q.size() != 0) @(negedge clk);

    // commit lane 3 only; blocked lane-0 load must not appear (R5, R4)
    @(posedge clk); #1;
    ld(3, {4{32'hF3F3_3333}}, 1, 1);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R5 drained", 512'(exp_q.size()), 512'd0);
    check(fab_valid == 0, "R7 empty after drain", 512'(fab_valid), 512'd0);

    // output register (R8, R9)
    @(posedge clk); #1;
    st_req = 1;
    @(negedge clk);
    check(st_valid == 0, "R9 store when empty", 512'(st_valid), 512'd0);
    @(posedge clk); #1;
    st_req = 0;
    res_valid = 1; res_data = {4{32'h1234_5678}};
    begin
      int t;
      t = 0;
      while (!res_stall && t < 20) begin @(negedge clk); t++; end
    end
    check(res_stall == 1, "R8 captured stall", 512'(res_stall), 512'd1);
    @(posedge clk); #1;
    res_data = {4{32'h9999_AAAA}};
    repeat (8) @(posedge clk);
    #1;
    res_valid = 0;
    @(negedge clk);
    check(st_data === {4{32'h1234_5678}}, "R8 not overwritten", 512'(st_data), 512'({4{32'h1234_5678}}));
    @(posedge clk); #1;
    st_req = 1;
    @(negedge clk);
    check(st_valid == 1, "R9 store valid", 512'(st_valid), 512'd1);
    check(st_data === {4{32'h1234_5678}}, "R9 store data", 512'(st_data), 512'({4{32'h1234_5678}}));
    @(posedge clk); #1;
    st_req = 0;
    @(negedge clk);
    check(res_stall == 0, "R9 emptied", 512'(res_stall), 512'd0);
    check(en_seen > 10, "R6 pulses seen", 512'(en_seen), 512'd11);
    finish_run();
  end
endmodule